// File: doc/BRIEF.md
# Universal Shift Register with Shared Parallel Bus

This block is a small storage and shift register with a parameterised width (eight bits by default). A two-bit mode select picks one of four operations on each rising clock edge: keep the contents, shift toward the high end, shift toward the low end, or load a whole word in parallel. An asynchronous active-low reset clears the register at any time, whatever the clock and the mode select are doing.

The parallel load data and the register contents share one bidirectional bus. The bus is modelled as an input vector, an output vector and a single drive enable. The drive turns off when either of two active-low enables is high. It also turns off whenever the mode select requests a parallel load, so that another agent can drive the word to be loaded.

Two serial outputs always carry the lowest and the highest bit of the register. Two serial inputs feed the vacated end bit during shifts. Wiring one register's serial outputs to a neighbour's serial inputs builds a longer shifter.

Top module: `usr_shift_bus`

## Requirements
- R1: While `rst_n` is low, every register bit is 0, whatever the clock and the mode select do; the clear takes effect without waiting for a clock edge.
- R2: With `sel_s1`=0 and `sel_s0`=0, a rising edge leaves the register unchanged, whatever is on `bus_in` and the serial inputs.
- R3: With `sel_s1`=1 and `sel_s0`=1, a rising edge copies `bus_in` into the register.
- R4: With `sel_s1`=0 and `sel_s0`=1, a rising edge moves each bit i to bit i+1 and puts `ser_in_r` into bit 0.
- R5: With `sel_s1`=1 and `sel_s0`=0, a rising edge moves each bit i to bit i-1 and puts `ser_in_l` into the top bit.
- R6: `bus_oe` is 1 exactly when `oe1_n`=0, `oe2_n`=0, and `sel_s0`/`sel_s1` are not both 1.
- R7: `bus_out` always equals the register contents, and all four operations and the reset work the same whether `bus_oe` is 0 or 1.
- R8: `ser_out_lo` always equals register bit 0 and `ser_out_hi` always equals the top register bit, independent of `bus_oe`.
- R9: Two instances with the low instance's `ser_out_hi` driving the high instance's `ser_in_r`, and the high instance's `ser_out_lo` driving the low instance's `ser_in_l`, behave as one shifter of twice the width in both shift directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on its rising edge |
| rst_n | input | 1 | Asynchronous clear, active low |
| sel_s0 | input | 1 | Mode select, low bit |
| sel_s1 | input | 1 | Mode select, high bit |
| ser_in_r | input | 1 | Serial bit entering bit 0 on a shift toward the high end |
| ser_in_l | input | 1 | Serial bit entering the top bit on a shift toward the low end |
| oe1_n | input | 1 | Bus drive enable, active low |
| oe2_n | input | 1 | Bus drive enable, active low |
| bus_in | input | WIDTH | Value seen on the shared bus; load source |
| bus_out | output | WIDTH | Register contents offered to the shared bus |
| bus_oe | output | 1 | Drive enable for the shared bus |
| ser_out_lo | output | 1 | Register bit 0 |
| ser_out_hi | output | 1 | Register top bit |

## Verification
The clocked assertions assume that the mode select, serial inputs and bus input are stable at each rising edge and are not unknown while reset is released. They also assume that reset is not released in the same instant as an edge. The bench changes every input on the falling clock edge, holds reset low across whole cycles, and drives only defined values. It makes one mid-cycle reset assertion, which it places a fraction of a period after a rising edge.

// File: rtl/usr_pkg.sv
package usr_pkg;

    // Operation chosen by {sel_s1, sel_s0}; the codes are behaviour.
    typedef enum logic [1:0] {
        MODE_HOLD = 2'b00,
        MODE_SHR  = 2'b01,
        MODE_SHL  = 2'b10,
        MODE_LOAD = 2'b11
    } usr_mode_e;

    typedef struct packed {
        usr_mode_e mode;
        logic      drive_en;
    } usr_ctrl_t;

    function automatic usr_mode_e usr_mode_of(input logic s1, input logic s0);
        return usr_mode_e'({s1, s0});
    endfunction

    function automatic logic usr_drive_of(input logic oe1_n, input logic oe2_n,
                                          input usr_mode_e mode);
        return !oe1_n && !oe2_n && (mode != MODE_LOAD);
    endfunction

endpackage

// File: rtl/usr_ctrl_dec.sv
module usr_ctrl_dec
    import usr_pkg::*;
(
    input  logic      sel_s0,
    input  logic      sel_s1,
    input  logic      oe1_n,
    input  logic      oe2_n,
    output usr_ctrl_t ctrl
);

    usr_mode_e mode_w;

    always_comb begin
        mode_w        = usr_mode_of(sel_s1, sel_s0);
        ctrl.mode     = mode_w;
        ctrl.drive_en = usr_drive_of(oe1_n, oe2_n, mode_w);
    end

endmodule

// File: rtl/usr_next_val.sv
module usr_next_val
    import usr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  usr_mode_e        mode,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] par_in,
    input  logic             ser_r,
    input  logic             ser_l,
    output logic [WIDTH-1:0] nxt
);

    localparam int TOP = WIDTH - 1;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic from_low;
        logic from_high;

        if (i == 0) begin : g_lo_end
            assign from_low = ser_r;
        end else begin : g_lo_mid
            assign from_low = cur[i-1];
        end

        if (i == TOP) begin : g_hi_end
            assign from_high = ser_l;
        end else begin : g_hi_mid
            assign from_high = cur[i+1];
        end

        always_comb begin
            unique case (mode)
                MODE_HOLD: nxt[i] = cur[i];
                MODE_SHR:  nxt[i] = from_low;
                MODE_SHL:  nxt[i] = from_high;
                MODE_LOAD: nxt[i] = par_in[i];
                default:   nxt[i] = cur[i];
            endcase
        end
    end

endmodule

// File: rtl/usr_state_reg.sv
module usr_state_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |-> (q == '0)); // R1

endmodule

// File: rtl/usr_shift_bus.sv
module usr_shift_bus
    import usr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_s0,
    input  logic             sel_s1,
    input  logic             ser_in_r,
    input  logic             ser_in_l,
    input  logic             oe1_n,
    input  logic             oe2_n,
    input  logic [WIDTH-1:0] bus_in,
    output logic [WIDTH-1:0] bus_out,
    output logic             bus_oe,
    output logic             ser_out_lo,
    output logic             ser_out_hi
);

    localparam int TOP = WIDTH - 1;

    usr_ctrl_t        ctrl;
    logic [WIDTH-1:0] nxt;
    logic [WIDTH-1:0] q;

    usr_ctrl_dec u_dec (
        .sel_s0 (sel_s0),
        .sel_s1 (sel_s1),
        .oe1_n  (oe1_n),
        .oe2_n  (oe2_n),
        .ctrl   (ctrl)
    );

    usr_next_val #(.WIDTH(WIDTH)) u_next (
        .mode   (ctrl.mode),
        .cur    (q),
        .par_in (bus_in),
        .ser_r  (ser_in_r),
        .ser_l  (ser_in_l),
        .nxt    (nxt)
    );

    usr_state_reg #(.WIDTH(WIDTH)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (nxt),
        .q     (q)
    );

    assign bus_out    = q;
    assign bus_oe     = ctrl.drive_en;
    assign ser_out_lo = q[0];
    assign ser_out_hi = q[TOP];

    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_s1 && !sel_s0) |=> $stable(bus_out)); // R2

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_s1 && sel_s0) |=> (bus_out == $past(bus_in))); // R3

    AST_SHR_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_s1 && sel_s0) |=>
        (bus_out == {$past(bus_out[TOP-1:0]), $past(ser_in_r)})); // R4

    AST_SHL_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_s1 && !sel_s0) |=>
        (bus_out == {$past(ser_in_l), $past(bus_out[TOP:1])})); // R5

    AST_NO_DRIVE_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_s1 && sel_s0) |-> !bus_oe); // R6

    AST_NO_DRIVE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (oe1_n || oe2_n) |-> !bus_oe); // R6

    AST_SER_ENDS: assert property (@(posedge clk)
        (ser_out_lo == bus_out[0]) && (ser_out_hi == bus_out[TOP])); // R8

endmodule

// File: tb/usr_shift_bus_tb.sv
module usr_shift_bus_tb;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sel_s0 = 1'b0, sel_s1 = 1'b0;
    logic         ser_in_r = 1'b0, ser_in_l = 1'b0;
    logic         oe1_n = 1'b0, oe2_n = 1'b0;
    logic [W-1:0] bus_in = '0;
    logic [W-1:0] bus_out;
    logic         bus_oe, ser_out_lo, ser_out_hi;

    always #2 clk = ~clk;

    usr_shift_bus #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .sel_s0(sel_s0), .sel_s1(sel_s1),
        .ser_in_r(ser_in_r), .ser_in_l(ser_in_l), .oe1_n(oe1_n), .oe2_n(oe2_n),
        .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
        .ser_out_lo(ser_out_lo), .ser_out_hi(ser_out_hi)
    );

    // Cascade pair (R9)
    logic         c_s0 = 1'b0, c_s1 = 1'b0, c_sr = 1'b0, c_sl = 1'b0;
    logic [W-1:0] c_bus_lo = '0, c_bus_hi = '0;
    logic [W-1:0] c_out_lo, c_out_hi;
    logic         c_oe_lo, c_oe_hi, lo_so_lo, lo_so_hi, hi_so_lo, hi_so_hi;

    usr_shift_bus #(.WIDTH(W)) u_c_lo (
        .clk(clk), .rst_n(rst_n), .sel_s0(c_s0), .sel_s1(c_s1),
        .ser_in_r(c_sr), .ser_in_l(hi_so_lo), .oe1_n(1'b0), .oe2_n(1'b0),
        .bus_in(c_bus_lo), .bus_out(c_out_lo), .bus_oe(c_oe_lo),
        .ser_out_lo(lo_so_lo), .ser_out_hi(lo_so_hi)
    );

    usr_shift_bus #(.WIDTH(W)) u_c_hi (
        .clk(clk), .rst_n(rst_n), .sel_s0(c_s0), .sel_s1(c_s1),
        .ser_in_r(lo_so_hi), .ser_in_l(c_sl), .oe1_n(1'b0), .oe2_n(1'b0),
        .bus_in(c_bus_hi), .bus_out(c_out_hi), .bus_oe(c_oe_hi),
        .ser_out_lo(hi_so_lo), .ser_out_hi(hi_so_hi)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [W-1:0] exp_q[$];
    logic         exp_oe[$];
    string        exp_tag[$];
    logic [W-1:0] model = '0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus and push the expected result.
    task automatic step(input logic s1, input logic s0, input logic dr, input logic dl,
                        input logic e1, input logic e2, input logic [W-1:0] b,
                        input logic rst);
        string tag;
        @(negedge clk);
        sel_s1 = s1; sel_s0 = s0; ser_in_r = dr; ser_in_l = dl;
        oe1_n = e1; oe2_n = e2; bus_in = b; rst_n = rst;
        if (!rst) begin
            model = '0; tag = "R1";
        end else begin
            case ({s1, s0})
                2'b00: tag = "R2";
                2'b11: begin model = b; tag = "R3"; end
                2'b01: begin model = {model[W-2:0], dr}; tag = "R4"; end
                default: begin model = {dl, model[W-1:1]}; tag = "R5"; end
            endcase
        end
        if (e1 || e2) tag = {tag, "/R7"};
        exp_q.push_back(model);
        exp_oe.push_back(!e1 && !e2 && !(s1 && s0));
        exp_tag.push_back(tag);
    endtask

    // Monitor: compare after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [W-1:0] eq;
                logic         eo;
                string        t;
                eq = exp_q.pop_front();
                eo = exp_oe.pop_front();
                t  = exp_tag.pop_front();
                check({t, " bus_out"}, bus_out, eq);
                check("R6 bus_oe", bus_oe, eo);
                check("R8 ser_out_lo", ser_out_lo, eq[0]);
                check("R8 ser_out_hi", ser_out_hi, eq[W-1]);
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] wide;
        #1;
        check("R1 reset value", bus_out, 8'h00);
        step(1, 1, 0, 0, 0, 0, 8'hFF, 0);   // load requested during reset
        step(0, 0, 0, 0, 0, 0, 8'h00, 1);
        step(1, 1, 0, 0, 0, 0, 8'hA5, 1);   // R3
        step(0, 0, 1, 1, 0, 0, 8'h3C, 1);   // R2 hold ignores bus and serial
        step(0, 0, 0, 1, 1, 0, 8'hFF, 1);   // R2 with drive off
        step(0, 1, 1, 0, 0, 0, 8'h00, 1);   // R4
        step(0, 1, 0, 0, 0, 1, 8'h00, 1);
        step(0, 1, 1, 1, 1, 1, 8'h00, 1);
        step(1, 0, 0, 1, 0, 0, 8'h00, 1);   // R5
        step(1, 0, 0, 0, 1, 0, 8'h00, 1);
        step(1, 0, 1, 1, 0, 0, 8'h00, 1);
        step(1, 1, 0, 0, 1, 1, 8'h5A, 1);   // R3 with drive off, R7
        for (int i = 0; i < 8; i++) step(0, 1, 1'(i % 3 == 0), 0, 0, 0, 8'h00, 1);
        for (int i = 0; i < 8; i++) step(1, 0, 0, 1'(i % 2), 0, 0, 8'h00, 1);
        // Mid-cycle reset during a shift (R1)
        step(1, 1, 0, 0, 0, 0, 8'hC3, 1);
        step(0, 1, 1, 0, 0, 0, 8'h00, 1);
        @(posedge clk);
        #2;
        rst_n = 1'b0;
        model = '0;
        #0.5;
        check("R1 async clear mid-cycle", bus_out, 8'h00);
        step(0, 1, 1, 1, 0, 0, 8'hFF, 0);
        step(1, 1, 1, 1, 0, 0, 8'hFF, 0);
        step(0, 0, 0, 0, 0, 0, 8'h00, 1);
        // Mixed traffic
        for (int i = 0; i < 60; i++)
            step(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                 1'($urandom), 1'($urandom), 8'($urandom), 1);
        @(negedge clk);
        @(negedge clk);

        // Cascade (R9): load then shift both ways as one 16-bit register
        c_s1 = 1; c_s0 = 1; c_bus_lo = 8'h81; c_bus_hi = 8'h3C;
        wide = {8'h3C, 8'h81};
        @(negedge clk);
        check("R9 cascade load", {c_out_hi, c_out_lo}, wide);
        for (int i = 0; i < 12; i++) begin
            c_s1 = 0; c_s0 = 1; c_sr = 1'(i % 3 != 1);
            wide = {wide[14:0], c_sr};
            @(negedge clk);
            check("R9 cascade shift up", {c_out_hi, c_out_lo}, wide);
        end
        for (int i = 0; i < 12; i++) begin
            c_s1 = 1; c_s0 = 0; c_sl = 1'(i % 2);
            wide = {c_sl, wide[15:1]};
            @(negedge clk);
            check("R9 cascade shift down", {c_out_hi, c_out_lo}, wide);
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule